// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Cell

This block is one programmable cell of a logic fabric. Its combinational part is a 16-entry, 1-bit wide memory addressed by four logic inputs, so any function of four variables can be realised by writing the matching truth table into it. A D flip-flop follows the table, so the cell can act as combinational logic or as a registered stage. The table is written bit by bit through a configuration port before normal operation begins. This stands in for the power-up programming of a real fabric.

In user mode a select bit chooses between the direct table output and the register output. The register has four controls, listed here by falling priority: an asynchronous clear, a synchronous clear, a synchronous load from a register-chain input, and a clock enable that gates every synchronous action. Cells can be cascaded in two ways. A carry chain serves arithmetic: in arithmetic mode the carry input takes the place of one table address bit, and a dedicated majority gate produces the carry output. A register chain exposes each register value so that the next cell can load it.

Top module: `lut_cell`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the truth table, the configuration progress and the register. After reset, `out`, `chain_out` and `carry_out` are 0.
- R2: While `cfg_en` is high and configuration is not complete, each rising clock edge shifts `cfg_bit` into the table. The first bit becomes entry 15 and the sixteenth bit becomes entry 0. Cycles with `cfg_en` low do not shift and do not count. The sixteenth shifted bit completes configuration.
- R3: Until configuration completes, `out`, `chain_out` and `carry_out` stay 0 whatever the other inputs do.
- R4: After configuration completes, `cfg_en` and `cfg_bit` have no effect until the next reset.
- R5: With `arith_mode` low, the table address is `lut_in`, where `lut_in[0]` is input a and `lut_in[3]` is input d. With `out_reg` low, `out` equals the addressed table entry in the same cycle.
- R6: With `arith_mode` high, `carry_in` replaces address bit 2 (`lut_in[2]`) of the table, and `carry_out` is the majority of `lut_in[0]`, `lut_in[1]` and `carry_in`. With `arith_mode` low, `carry_out` is 0.
- R7: With `out_reg` high, `out` equals the register value. With `out_reg` low, `out` is the table output.
- R8: `aclr` high forces the register to 0 at once, without waiting for a clock edge, and holds it there over every other control.
- R9: With `ce` low, the register keeps its value at a clock edge, even when `sclr` or `sload` is high.
- R10: With `ce` high, `sclr` high clears the register at the clock edge, even when `sload` is also high.
- R11: With `ce` high and `sclr` low, the register loads `chain_in` at the clock edge when `sload` is high, and otherwise loads the table output addressed as in R5 and R6.
- R12: `chain_out` always equals the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial truth-table bit, highest entry first |
| lut_in | input | 4 | Logic inputs a (bit 0) to d (bit 3) |
| arith_mode | input | 1 | Arithmetic mode: carry_in drives address bit 2 |
| out_reg | input | 1 | 1 selects the register for `out`, 0 selects the table |
| ce | input | 1 | Register clock enable |
| aclr | input | 1 | Asynchronous register clear |
| sclr | input | 1 | Synchronous register clear |
| sload | input | 1 | Synchronous load from chain_in |
| chain_in | input | 1 | Register-chain input from the previous cell |
| carry_in | input | 1 | Carry input from the previous cell |
| out | output | 1 | Cell output |
| chain_out | output | 1 | Register value for the next cell |
| carry_out | output | 1 | Carry output for the next cell |

## Verification
The hardest state to reach is a register whose value is known and different from zero, then hit by overlapping controls: `aclr` rising between clock edges while `ce`, `sload` and `chain_in` would load a 1, or `sclr` and `sload` arriving together. The bench preloads a 1 through the register chain and then applies each overlap in a directed sequence. A long random phase then mixes all the controls while a bench model tracks the register. Configuration is also interrupted by a pause with noise on `cfg_bit`, and attempted again after it completes, to show that only the sixteen enabled bits land in the table.

// File: rtl/lut_cell_pkg.sv
`timescale 1ns/1ps
package lut_cell_pkg;

    localparam int LUT_K     = 4;
    localparam int LUT_DEPTH = 1 << LUT_K;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_ZERO  = 2'd1,
        OP_CHAIN = 2'd2,
        OP_DATA  = 2'd3
    } ff_op_e;

    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;

    typedef struct packed {
        logic ce;
        logic sclr;
        logic sload;
    } ff_ctl_t;

    function automatic logic majority(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Priority after the asynchronous clear: unconfigured, enable, clear, load, data
    function automatic ff_op_e pick_op(input ff_ctl_t c, input logic live);
        if (!live)        return OP_ZERO;
        else if (!c.ce)   return OP_HOLD;
        else if (c.sclr)  return OP_ZERO;
        else if (c.sload) return OP_CHAIN;
        else              return OP_DATA;
    endfunction

endpackage

// File: rtl/lut_cfg_store.sv
`timescale 1ns/1ps
module lut_cfg_store #(
    parameter int K = lut_cell_pkg::LUT_K
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_bit,
    input  logic [K-1:0] addr,
    output logic         lut_q,
    output logic         done
);
    localparam int DEPTH = 1 << K;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic [DEPTH-1:0] mem;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem  <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (cfg_en && !done) begin
            mem <= {mem[DEPTH-2:0], cfg_bit};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DEPTH - 1)) begin
                done <= 1'b1;
            end
        end
    end

    assign lut_q = mem[addr];

endmodule

// File: rtl/lut_carry_logic.sv
`timescale 1ns/1ps
module lut_carry_logic #(
    parameter int K       = lut_cell_pkg::LUT_K,
    parameter int CIN_POS = 2
) (
    input  logic [K-1:0] sel,
    input  logic         carry_in,
    input  logic         arith,
    output logic [K-1:0] addr,
    output logic         carry_raw
);
    import lut_cell_pkg::*;

    for (genvar i = 0; i < K; i++) begin : g_addr
        if (i == CIN_POS) begin : g_cin
            assign addr[i] = arith ? carry_in : sel[i];
        end else begin : g_pass
            assign addr[i] = sel[i];
        end
    end

    assign carry_raw = arith & majority(sel[0], sel[1], carry_in);

endmodule

// File: rtl/lut_ff_ctrl.sv
`timescale 1ns/1ps
module lut_ff_ctrl
    import lut_cell_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    aclr,
    input  logic    live,
    input  ff_ctl_t ctl,
    input  logic    d_in,
    input  logic    chain_in,
    output logic    q
);
    ff_op_e op;

    always_comb begin
        op = pick_op(ctl, live);
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            q <= 1'b0;
        end else if (rst) begin
            q <= 1'b0;
        end else begin
            case (op)
                OP_HOLD:  q <= q;
                OP_ZERO:  q <= 1'b0;
                OP_CHAIN: q <= chain_in;
                OP_DATA:  q <= d_in;
                default:  q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_bit,
    input  logic [K-1:0] lut_in,
    input  logic         arith_mode,
    input  logic         out_reg,
    input  logic         ce,
    input  logic         aclr,
    input  logic         sclr,
    input  logic         sload,
    input  logic         chain_in,
    input  logic         carry_in,
    output logic         out,
    output logic         chain_out,
    output logic         carry_out
);
    logic [K-1:0] lut_addr;
    logic         carry_raw;
    logic         lut_q;
    logic         cfg_done;
    logic         ff_q;
    ff_ctl_t      ctl;
    path_e        path;

    lut_carry_logic #(.K(K), .CIN_POS(2)) u_carry (
        .sel       (lut_in),
        .carry_in  (carry_in),
        .arith     (arith_mode),
        .addr      (lut_addr),
        .carry_raw (carry_raw)
    );

    lut_cfg_store #(.K(K)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .addr    (lut_addr),
        .lut_q   (lut_q),
        .done    (cfg_done)
    );

    assign ctl = '{ce: ce, sclr: sclr, sload: sload};

    lut_ff_ctrl u_ff (
        .clk      (clk),
        .rst      (rst),
        .aclr     (aclr),
        .live     (cfg_done),
        .ctl      (ctl),
        .d_in     (lut_q),
        .chain_in (chain_in),
        .q        (ff_q)
    );

    assign path      = out_reg ? PATH_REG : PATH_COMB;
    assign out       = cfg_done & ((path == PATH_REG) ? ff_q : lut_q);
    assign chain_out = ff_q;
    assign carry_out = cfg_done & carry_raw;

endmodule

// File: rtl/lut_cell_chk.sv
`timescale 1ns/1ps
module lut_cell_chk #(
    parameter int K = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         aclr,
    input logic         ce,
    input logic         sclr,
    input logic         sload,
    input logic         chain_in,
    input logic         arith_mode,
    input logic [K-1:0] lut_in,
    input logic         carry_in,
    input logic         out,
    input logic         chain_out,
    input logic         carry_out,
    input logic         live
);
    AST_UNCONFIG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !live |-> (!out && !carry_out && !chain_out)); // R3

    AST_ACLR_WINS: assert property (@(posedge clk) disable iff (rst)
        aclr |-> !chain_out); // R8

    AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst || aclr)
        (live && !ce) |=> (chain_out == $past(chain_out))); // R9

    AST_SCLR_FIRST: assert property (@(posedge clk) disable iff (rst || aclr)
        (live && ce && sclr) |=> !chain_out); // R10

    AST_SLOAD_CHAIN: assert property (@(posedge clk) disable iff (rst || aclr)
        (live && ce && !sclr && sload) |=> (chain_out == $past(chain_in))); // R11

    AST_CARRY_GEN: assert property (@(posedge clk) disable iff (rst)
        (live && arith_mode && lut_in[0] && lut_in[1]) |-> carry_out); // R6

    AST_CARRY_KILL: assert property (@(posedge clk) disable iff (rst)
        (!arith_mode || (!lut_in[0] && !lut_in[1]) || (!carry_in && !(lut_in[0] && lut_in[1])))
        |-> !carry_out); // R6

endmodule

bind lut_cell lut_cell_chk #(.K(K)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .aclr       (aclr),
    .ce         (ce),
    .sclr       (sclr),
    .sload      (sload),
    .chain_in   (chain_in),
    .arith_mode (arith_mode),
    .lut_in     (lut_in),
    .carry_in   (carry_in),
    .out        (out),
    .chain_out  (chain_out),
    .carry_out  (carry_out),
    .live       (cfg_done)
);

// File: tb/sim_lut_cell.sv
`timescale 1ns/1ps
module sim_lut_cell;
    logic clk = 1'b0;
    logic rst, cfg_en, cfg_bit, arith_mode, out_reg, ce, aclr, sclr, sload, chain_in, carry_in;
    logic [3:0] lut_in;
    logic out, chain_out, carry_out;

    int errs = 0;
    int checks = 0;
    logic [15:0] tt;
    logic mq;
    logic nxt;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lut_cell u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .lut_in(lut_in),
        .arith_mode(arith_mode), .out_reg(out_reg), .ce(ce), .aclr(aclr), .sclr(sclr),
        .sload(sload), .chain_in(chain_in), .carry_in(carry_in),
        .out(out), .chain_out(chain_out), .carry_out(carry_out)
    );

    function automatic logic [3:0] exp_addr(input logic [3:0] s, input logic c, input logic ar);
        return ar ? {s[3], c, s[1], s[0]} : s;
    endfunction

    function automatic logic exp_carry(input logic [3:0] s, input logic c, input logic ar);
        return ar & ((s[0] & s[1]) | (s[0] & c) | (s[1] & c));
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; cfg_en = 0; cfg_bit = 0; lut_in = 0; arith_mode = 0; out_reg = 0;
        ce = 0; aclr = 0; sclr = 0; sload = 0; chain_in = 0; carry_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(out, 1'b0, "R1 out after reset");
        chk(chain_out, 1'b0, "R1 chain_out after reset");
        chk(carry_out, 1'b0, "R1 carry_out after reset");

        // R3: unconfigured cell stays quiet
        @(negedge clk);
        arith_mode = 1; lut_in = 4'b1111; carry_in = 1; ce = 1; sload = 1; chain_in = 1; out_reg = 1;
        @(posedge clk); #1;
        chk(carry_out, 1'b0, "R3 carry_out before config");
        chk(out, 1'b0, "R3 out before config");
        chk(chain_out, 1'b0, "R3 chain_out before config");
        @(negedge clk);
        arith_mode = 0; ce = 0; sload = 0; chain_in = 0; out_reg = 0; carry_in = 0;

        // R2: serial load, highest entry first, with a pause
        tt = 16'($urandom);
        tt[15] = 1'b1; tt[0] = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (i == 7) begin
                @(negedge clk); cfg_en = 0; cfg_bit = ~tt[i];
                @(negedge clk); cfg_en = 0; cfg_bit = tt[i];
            end
            @(negedge clk); cfg_en = 1; cfg_bit = tt[i];
            if (i == 3) begin
                lut_in = 4'hF; #1;
                chk(out, 1'b0, "R2 R3 out during partial config");
            end
        end
        @(negedge clk); cfg_en = 0;

        // R4: further configuration attempts are ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); cfg_en = 1; cfg_bit = ~cfg_bit;
        end
        @(negedge clk); cfg_en = 0;

        // R5: every address in combinational mode
        for (int a = 0; a < 16; a++) begin
            @(negedge clk); lut_in = 4'(a); #1;
            chk(out, tt[a], "R2 R4 R5 table lookup");
            chk(carry_out, 1'b0, "R6 carry_out outside arith");
        end

        // R6: arithmetic addressing and carry
        arith_mode = 1;
        for (int v = 0; v < 32; v++) begin
            @(negedge clk); lut_in = 4'(v); carry_in = v[4]; #1;
            chk(out, tt[exp_addr(lut_in, carry_in, 1'b1)], "R6 arith address");
            chk(carry_out, exp_carry(lut_in, carry_in, 1'b1), "R6 carry majority");
        end
        arith_mode = 0; carry_in = 0;

        // Directed register controls
        @(negedge clk); out_reg = 1; ce = 1; sload = 1; chain_in = 1;
        @(posedge clk); #1;
        chk(chain_out, 1'b1, "R11 sload from chain_in");
        chk(out, 1'b1, "R7 out follows register");
        @(negedge clk); ce = 0; sload = 1; sclr = 1; chain_in = 0;
        @(posedge clk); #1;
        chk(chain_out, 1'b1, "R9 ce low holds");
        @(negedge clk); ce = 1; sclr = 1; sload = 1; chain_in = 1;
        @(posedge clk); #1;
        chk(chain_out, 1'b0, "R10 sclr over sload");
        @(negedge clk); sclr = 0; sload = 1; chain_in = 1;
        @(posedge clk); #1;
        chk(chain_out, 1'b1, "R12 chain_out equals register");
        @(negedge clk); #2; aclr = 1; #1;
        chk(chain_out, 1'b0, "R8 async clear immediate");
        chk(out, 1'b0, "R8 out cleared");
        @(posedge clk); #1;
        chk(chain_out, 1'b0, "R8 clear beats sload");
        @(negedge clk); aclr = 0; ce = 0; sload = 0; chain_in = 0; out_reg = 0;
        mq = 1'b0;

        // Random phase against the bench model
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            lut_in = 4'($urandom); carry_in = 1'($urandom); arith_mode = 1'($urandom);
            out_reg = 1'($urandom); ce = ($urandom % 4) != 0; sclr = ($urandom % 8) == 0;
            sload = ($urandom % 6) == 0; chain_in = 1'($urandom); aclr = ($urandom % 16) == 0;
            cfg_en = 1'($urandom); cfg_bit = 1'($urandom);
            if (aclr) mq = 1'b0;
            #1;
            chk(out, out_reg ? mq : tt[exp_addr(lut_in, carry_in, arith_mode)], "R5 R7 random out");
            chk(carry_out, exp_carry(lut_in, carry_in, arith_mode), "R6 random carry");
            if (aclr) nxt = 1'b0;
            else if (!ce) nxt = mq;
            else if (sclr) nxt = 1'b0;
            else if (sload) nxt = chain_in;
            else nxt = tt[exp_addr(lut_in, carry_in, arith_mode)];
            @(posedge clk); #1;
            mq = nxt;
            chk(chain_out, mq, "R8 R9 R10 R11 R12 random register");
        end

        // R1: reset clears the table
        @(negedge clk); aclr = 0; cfg_en = 0; rst = 1; arith_mode = 0; out_reg = 0; lut_in = 4'hF;
        @(posedge clk); #1;
        @(negedge clk); rst = 0; #1;
        chk(out, 1'b0, "R1 table cleared by reset");
        chk(chain_out, 1'b0, "R1 register cleared by reset");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule